// File: doc/BRIEF.md
# Vector Shifter with Wide Shift Amounts

This block shifts every narrow element of a vector by a count drawn from a second vector. The second vector is read as a row of 64-bit unsigned words. Every byte, halfword or word element takes its count from the one 64-bit word that covers the same 64-bit segment of the vector. The operations are arithmetic right shift, logical right shift and logical left shift. There is no predication, so every destination element is written.

A request is presented with `in_valid`, an operation code, a size code and the two operand vectors. One clock later the block either registers the result and raises `out_valid`, or raises `illegal` for an unallocated encoding and keeps the previous result. The vector width `VLEN` is a parameter and must be a multiple of 64. A count at or beyond the element width saturates. Logical shifts then give zero, and the arithmetic shift fills the element with its sign bit. The comparison uses all 64 bits of the count.

Top module: `vshift_wide`

## Requirements
- R1: While `rst_n` is low and after its release, `result` is zero and `out_valid` and `illegal` are low until a request is accepted.
- R2: A legal request with `in_valid` high at a rising edge makes `out_valid` high and `result` valid in the cycle after that edge.
- R3: Vector bits [64k+63:64k] of `src_vec` form segment k. Every element in segment k is shifted by the unsigned 64-bit count `amt_vec[64k+63:64k]`. A different count in each segment gives a different result in each segment.
- R4: `op` encodes 2'b00 as arithmetic right shift, 2'b01 as logical right shift and 2'b11 as logical left shift.
- R5: `esz` encodes 2'b00 as 8-bit, 2'b01 as 16-bit and 2'b10 as 32-bit elements. Element i of width w occupies bits [i*w+w-1:i*w].
- R6: In a logical shift, a count greater than or equal to the element width gives a zero element. This includes counts whose only set bits lie above bit 31, and counts of 2^64-1.
- R7: In an arithmetic right shift, a count greater than or equal to the element width gives an element filled with its sign bit. A count of width-1 gives the same value.
- R8: A request with `esz` = 2'b11 or `op` = 2'b10 raises `illegal` and leaves `out_valid` low in the next cycle. `result` keeps its previous value.
- R9: A cycle without `in_valid` gives low `out_valid` and `illegal` in the next cycle, and `result` is unchanged.
- R10: With `VLEN` = 128 the block computes the same result as the low 128 bits of a 256-bit instance that has the same low operand bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 2 | Shift kind: 00 arithmetic right, 01 logical right, 11 logical left |
| esz | input | 2 | Element size: 00 byte, 01 halfword, 10 word, 11 illegal |
| src_vec | input | VLEN | Elements to shift |
| amt_vec | input | VLEN | One 64-bit unsigned count per segment |
| result | output | VLEN | Registered shifted vector |
| out_valid | output | 1 | Result of a legal request is present |
| illegal | output | 1 | Previous request had an unallocated encoding |

## Verification
Each table row gives segment k the count c+k, so one request tests four neighbouring counts. Those counts are placed around 0, width-1, width and width+1, and a mismatch there shows an off-by-one in the saturation compare. Counts of 2^32 and of 2^64-2 (which wraps to 0 and 1 in the upper segments) show whether the compare reads all 64 bits. Source patterns with mixed sign bits in every lane separate arithmetic fill from logical zeroing and show whether lanes are kept apart. A 128-bit instance that runs alongside shows that the segment count follows the parameter.

// File: rtl/vsw_pkg.sv
package vsw_pkg;
  typedef enum logic [1:0] {
    SH_ASR = 2'b00,
    SH_LSR = 2'b01,
    SH_NONE = 2'b10,
    SH_LSL = 2'b11
  } shop_e;

  typedef enum logic [1:0] {
    SZ_B = 2'b00,
    SZ_H = 2'b01,
    SZ_W = 2'b10,
    SZ_BAD = 2'b11
  } size_e;

  localparam int SEG_W = 64;

  // A count saturates once it reaches the lane width; every bit counts.
  function automatic logic amt_saturates(input logic [63:0] amt, input int lane_w);
    return amt >= 64'(lane_w);
  endfunction

  function automatic logic enc_illegal(input shop_e op, input size_e esz);
    return (esz == SZ_BAD) || (op == SH_NONE);
  endfunction
endpackage

// File: rtl/vsw_lane.sv
module vsw_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0]      val,
  input  logic [63:0]       amt,
  input  vsw_pkg::shop_e    op,
  output logic [W-1:0]      res
);
  localparam int CW = $clog2(W);

  logic          over;
  logic [CW-1:0] cnt;

  assign over = vsw_pkg::amt_saturates(amt, W);
  assign cnt  = amt[CW-1:0];

  always_comb begin
    case (op)
      vsw_pkg::SH_ASR: res = over ? {W{val[W-1]}} : W'($signed(val) >>> cnt);
      vsw_pkg::SH_LSR: res = over ? '0 : (val >> cnt);
      vsw_pkg::SH_LSL: res = over ? '0 : (val << cnt);
      default:         res = '0;
    endcase
  end
endmodule

// File: rtl/vsw_segment.sv
module vsw_segment (
  input  logic [63:0]    src,
  input  logic [63:0]    amt,
  input  vsw_pkg::shop_e op,
  input  vsw_pkg::size_e esz,
  output logic [63:0]    res
);
  localparam int NB = 64 / 8;
  localparam int NH = 64 / 16;
  localparam int NW = 64 / 32;

  logic [63:0] r_b, r_h, r_w;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    vsw_lane #(.W(8)) u_lane (.val(src[i*8 +: 8]), .amt(amt), .op(op), .res(r_b[i*8 +: 8]));
  end
  for (genvar i = 0; i < NH; i++) begin : g_half
    vsw_lane #(.W(16)) u_lane (.val(src[i*16 +: 16]), .amt(amt), .op(op), .res(r_h[i*16 +: 16]));
  end
  for (genvar i = 0; i < NW; i++) begin : g_word
    vsw_lane #(.W(32)) u_lane (.val(src[i*32 +: 32]), .amt(amt), .op(op), .res(r_w[i*32 +: 32]));
  end

  always_comb begin
    case (esz)
      vsw_pkg::SZ_B: res = r_b;
      vsw_pkg::SZ_H: res = r_h;
      vsw_pkg::SZ_W: res = r_w;
      default:       res = '0;
    endcase
  end
endmodule

// File: rtl/vshift_wide.sv
module vshift_wide #(
  parameter int VLEN = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [1:0]      op,
  input  logic [1:0]      esz,
  input  logic [VLEN-1:0] src_vec,
  input  logic [VLEN-1:0] amt_vec,
  output logic [VLEN-1:0] result,
  output logic            out_valid,
  output logic            illegal
);
  localparam int NSEG = VLEN / vsw_pkg::SEG_W;

  vsw_pkg::shop_e  op_q;
  vsw_pkg::size_e  esz_q;
  logic            enc_bad;
  logic            take_ok;
  logic            take_bad;
  logic [VLEN-1:0] shifted;

  assign op_q     = vsw_pkg::shop_e'(op);
  assign esz_q    = vsw_pkg::size_e'(esz);
  assign enc_bad  = vsw_pkg::enc_illegal(op_q, esz_q);
  assign take_ok  = in_valid && !enc_bad;
  assign take_bad = in_valid && enc_bad;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    vsw_segment u_seg (
      .src(src_vec[s*64 +: 64]),
      .amt(amt_vec[s*64 +: 64]),
      .op (op_q),
      .esz(esz_q),
      .res(shifted[s*64 +: 64])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result    <= '0;
      out_valid <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= take_ok;
      illegal   <= take_bad;
      if (take_ok) result <= shifted;
    end
  end
endmodule

// File: rtl/vshift_wide_checker.sv
module vshift_wide_checker #(
  parameter int VLEN = 256
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [1:0]      op,
  input logic [1:0]      esz,
  input logic            enc_bad,
  input logic [VLEN-1:0] result,
  input logic            out_valid,
  input logic            illegal
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_legal_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(in_valid) && !$past(enc_bad)) |-> out_valid);

  p_bad_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(in_valid) && ($past(esz) == 2'b11 || $past(op) == 2'b10))
      |-> (illegal && !out_valid));

  p_bad_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $stable(result));

  p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && illegal));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(in_valid)) |-> (!out_valid && !illegal && $stable(result)));
endmodule

bind vshift_wide vshift_wide_checker #(.VLEN(VLEN)) u_vshift_wide_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .esz(esz),
  .enc_bad(enc_bad), .result(result), .out_valid(out_valid), .illegal(illegal)
);

// File: tb/vshift_wide_bench.sv
module vshift_wide_bench;
  localparam int V = 256;
  localparam int VN = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [1:0]    op = 2'b00;
  logic [1:0]    esz = 2'b00;
  logic [V-1:0]  src_vec = '0;
  logic [V-1:0]  amt_vec = '0;
  logic [V-1:0]  result;
  logic          out_valid, illegal;
  logic [VN-1:0] result_n;
  logic          out_valid_n, illegal_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vshift_wide #(.VLEN(V)) u_vshift_wide (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .esz(esz),
    .src_vec(src_vec), .amt_vec(amt_vec), .result(result),
    .out_valid(out_valid), .illegal(illegal)
  );

  vshift_wide #(.VLEN(VN)) u_vshift_wide_n128 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .esz(esz),
    .src_vec(src_vec[VN-1:0]), .amt_vec(amt_vec[VN-1:0]), .result(result_n),
    .out_valid(out_valid_n), .illegal(illegal_n)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  esz;
    logic [63:0] amt;
    logic [63:0] pat;
  } vec_t;

  localparam int NT = 16;
  localparam vec_t TBL [NT] = '{
    '{2'b00, 2'b00, 64'd0,                    64'h8F01_7F80_C3A5_0F7E},
    '{2'b00, 2'b00, 64'd7,                    64'hF00D_80FF_017F_A55A},
    '{2'b01, 2'b00, 64'd7,                    64'hFF80_0102_7F40_C3E1},
    '{2'b11, 2'b00, 64'd3,                    64'h0123_4567_89AB_CDEF},
    '{2'b00, 2'b01, 64'd14,                   64'h8001_7FFF_C000_1234},
    '{2'b01, 2'b01, 64'd15,                   64'hFFFF_8000_4321_ABCD},
    '{2'b11, 2'b01, 64'd16,                   64'h0001_FFFF_8000_7A5A},
    '{2'b00, 2'b10, 64'd30,                   64'h8000_0001_7FFF_FFFF},
    '{2'b01, 2'b10, 64'd31,                   64'hFFFF_FFFF_8765_4321},
    '{2'b11, 2'b10, 64'd1,                    64'hC000_0000_4000_0001},
    '{2'b00, 2'b10, 64'h0000_0001_0000_0000,  64'h9ABC_DEF0_1234_5678},
    '{2'b01, 2'b00, 64'h0000_0001_0000_0000,  64'hFFFF_FFFF_FFFF_FFFF},
    '{2'b11, 2'b01, 64'hFFFF_FFFF_FFFF_FFFE,  64'hA5A5_5A5A_FFFF_0001},
    '{2'b00, 2'b01, 64'h8000_0000_0000_0000,  64'h8123_0456_F000_7FFF},
    '{2'b01, 2'b10, 64'd0,                    64'hDEAD_BEEF_0BAD_F00D},
    '{2'b00, 2'b00, 64'hFFFF_FFFF_FFFF_FFFE,  64'h7F80_01FE_8040_20C0}
  };

  // Behavioural reference: lanes handled in 64-bit arithmetic.
  function automatic logic [V-1:0] model(input logic [1:0] o, input logic [1:0] s,
                                         input logic [V-1:0] a, input logic [V-1:0] b);
    logic [V-1:0] r = '0;
    int w = 8 << s;
    for (int seg = 0; seg < V / 64; seg++) begin
      logic [63:0] cnt = b[seg*64 +: 64];
      logic [63:0] seg_v = a[seg*64 +: 64];
      for (int l = 0; l < 64 / w; l++) begin
        logic [63:0] m = (64'd1 << w) - 64'd1;
        logic [63:0] v = (seg_v >> (l * w)) & m;
        logic [63:0] x;
        if (o == 2'b00) begin
          logic [63:0] sv = v[w-1] ? (v | ~m) : v;
          x = (cnt >= 64'd63) ? 64'($signed(sv) >>> 63) : 64'($signed(sv) >>> cnt[5:0]);
        end else if (o == 2'b01) begin
          x = (cnt >= 64'd64) ? 64'd0 : (v >> cnt[5:0]);
        end else begin
          x = (cnt >= 64'd64) ? 64'd0 : (v << cnt[5:0]);
        end
        r[seg*64 +: 64] = r[seg*64 +: 64] | ((x & m) << (l * w));
      end
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [V-1:0] act,
                     input logic [V-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input vec_t t);
    @(negedge clk);
    op = t.op;
    esz = t.esz;
    for (int k = 0; k < V / 64; k++) begin
      logic [63:0] rot = (k == 0) ? t.pat : ((t.pat << (8 * k)) | (t.pat >> (64 - 8 * k)));
      src_vec[k*64 +: 64] = rot;
      amt_vec[k*64 +: 64] = t.amt + 64'(k);
    end
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    logic [V-1:0] expv;
    logic [V-1:0] held;
    repeat (3) @(negedge clk);
    chk(result == '0, "R1 reset result", result, '0);
    chk(!out_valid && !illegal, "R1 reset flags", {out_valid, illegal}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !illegal && result == '0, "R1 after release", result, '0);

    for (int i = 0; i < NT; i++) begin
      load(TBL[i]);
      expv = model(TBL[i].op, TBL[i].esz, src_vec, amt_vec);
      chk(out_valid && !illegal, "R2 valid after legal request", {out_valid, illegal}, 2'b10);
      chk(result == expv, "R3/R4/R5/R6/R7 table row", result, expv);
      chk(result_n == expv[VN-1:0], "R10 narrow instance", result_n, expv[VN-1:0]);
    end

    // R6: logical right by 2^32 on words gives zero in every segment
    load('{2'b01, 2'b10, 64'h0000_0001_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF});
    chk(result == '0, "R6 high-bit count zeroes", result, '0);
    // R7: arithmetic right saturates to sign fill
    load('{2'b00, 2'b00, 64'd8, 64'h8080_8080_8080_8080});
    chk(result == {V{1'b1}}, "R7 sign fill", result, {V{1'b1}});
    held = result;

    // R8: size code 3 flagged, result held
    @(negedge clk);
    op = 2'b00; esz = 2'b11; src_vec = '0; amt_vec = '0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(illegal && !out_valid, "R8 size 3 flagged", {out_valid, illegal}, 2'b01);
    chk(result == held, "R8 result held on size 3", result, held);
    // R8: op code 10 flagged
    @(negedge clk);
    op = 2'b10; esz = 2'b00; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(illegal && !out_valid, "R8 op 10 flagged", {out_valid, illegal}, 2'b01);
    chk(result == held, "R8 result held on op 10", result, held);

    // R9: idle cycle leaves everything quiet
    @(negedge clk);
    chk(!out_valid && !illegal, "R9 idle flags", {out_valid, illegal}, '0);
    chk(result == held, "R9 idle result", result, held);

    // R3: distinct counts per segment, logical left on bytes
    @(negedge clk);
    op = 2'b11; esz = 2'b00;
    src_vec = {4{64'h0101_0101_0101_0101}};
    amt_vec = {64'd7, 64'd8, 64'd1, 64'd0};
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    expv = {64'h8080_8080_8080_8080, 64'd0, 64'h0202_0202_0202_0202, 64'h0101_0101_0101_0101};
    chk(result == expv, "R3 per-segment count", result, expv);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule